// File: doc/BRIEF.md
# Deep Stop Power Sequencer

This block steps a microcontroller into and out of its lowest-power stop level. A STOP request from the CPU takes effect only while the deepest level is selected. The block then gates the peripheral clocks and forces every I/O pad to its reset default. After a short settling phase it switches the core power domain off. The debug clock can be kept running by a separate enable; the peripheral clocks cannot.

Two sources end the stop. One is a low level on an active-low wake pin, which is asynchronous and passes through a synchronizer. The other is a real-time interrupt tick, which counts only when its wake enable is set. Leaving the deepest level is a full power-on style restart: core power returns and the system reset output is held for a fixed count. The reset is then held further for as long as the supply monitor reports a low supply. When the wake is detected, a sticky power-down flag in the always-on domain is set. Software reads this flag to choose its recovery path and clears it by writing one to an acknowledge input. A true power-on reset clears the flag; a wake restart does not.

Top module: `stop_pwr_ctl`

## Requirements
- R1: One clock edge after `stop_req` is high with `deep_sel` high in the run state, `periph_clk_en` is 0 and `io_force_default` is 1. `core_pwr_on` stays 1 for ENTRY_CYCLES (default 2) observed cycles and is then 0. `io_force_default` is 1 whenever the core is off.
- R2: `stop_req` while `deep_sel` is 0 has no effect: the block stays in the run state, with `periph_clk_en` 1 and `io_force_default` 0.
- R3: In the stopped state, `wake_pin_n` is 0 at one rising clock edge (edge k). The stopped outputs hold after edges k and k+1, and `sys_rst` and `core_pwr_on` are 1 after edge k+2. A low wake pin in the run state has no effect.
- R4: In the stopped state, `rti_tick` with `rti_wake_en` 1 starts the wake restart at the next edge. A tick with `rti_wake_en` 0 is ignored.
- R5: After a wake or a power-on reset, `sys_rst` is 1 for exactly RST_CYCLES (default 16) cycles when `lvd_ok` is 1.
- R6: While `lvd_ok` is 0 the reset is not released. One edge after `lvd_ok` returns to 1, with the count already complete, `sys_rst` is 0.
- R7: `pdown_flag` becomes 1 on the edge that starts a wake restart and is kept through that restart. `ack_wr` clears it one edge later, but only in the run state; `ack_wr` during reset is ignored.
- R8: While `por_n` is 0: `sys_rst`=1, `pdown_flag`=0, `periph_clk_en`=0, `io_force_default`=1 and `core_pwr_on`=1.
- R9: `periph_clk_en` is 1 only in the run state. `dbg_clk_en` is 1 in the run state and otherwise equals `dbg_en`.
- R10: `wake_pu_en` follows `wake_pu_cfg` in every state; stop entry does not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| por_n | input | 1 | True power-on reset, asynchronous, active low |
| stop_req | input | 1 | CPU executed STOP (one-cycle pulse) |
| deep_sel | input | 1 | Deepest stop level selected |
| wake_pin_n | input | 1 | Asynchronous active-low wake pin |
| rti_tick | input | 1 | Real-time interrupt tick |
| rti_wake_en | input | 1 | Tick may wake from stop |
| dbg_en | input | 1 | Background debug enabled |
| lvd_ok | input | 1 | Supply above low-voltage trip point |
| ack_wr | input | 1 | Software write of one to the flag acknowledge |
| wake_pu_cfg | input | 1 | Wake pin pull-up enable setting |
| periph_clk_en | output | 1 | Peripheral clock enable |
| dbg_clk_en | output | 1 | Debug clock enable |
| io_force_default | output | 1 | Force pads to reset defaults |
| core_pwr_on | output | 1 | Core power domain switch |
| sys_rst | output | 1 | System reset, active high |
| pdown_flag | output | 1 | Sticky power-down flag |
| wake_pu_en | output | 1 | Wake pin pull-up control |

## Verification
Each result has its own latency after its stimulus:
- Clock gating and pad forcing follow one edge after a STOP request, and core power drops after ENTRY_CYCLES edges.
- An RTI wake needs one edge.
- A wake pin level needs three edges: two for the synchronizer and one for the state register.
- The flag sets on the same edge that starts the reset, and an acknowledge clears it one edge later.
- The reset lasts RST_CYCLES cycles plus any time spent with a low supply.

A behavioural reference model in the bench advances on each rising edge and is compared with every output shortly after that edge. Directed checks drive on falling edges and sample at the falling edge where the edge count above places each change.

// File: rtl/spc_pkg.sv
package spc_pkg;

  typedef enum logic [1:0] {
    PM_RUN      = 2'd0,
    PM_ENTER    = 2'd1,
    PM_STOPPED  = 2'd2,
    PM_WAKE_RST = 2'd3
  } pm_state_e;

  // Counter width able to hold the larger of two cycle counts minus one.
  function automatic int unsigned spc_cnt_width(input int unsigned a, input int unsigned b);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > 1) ? $clog2(m) + 1 : 1;
  endfunction

  // A phase lasting 'cycles' cycles starts its down-counter here and ends at zero.
  function automatic int unsigned spc_load(input int unsigned cycles);
    return (cycles > 0) ? cycles - 1 : 0;
  endfunction

endpackage

// File: rtl/spc_wake_sync.sv
module spc_wake_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic por_n,
  input  logic pin_n,
  output logic pin_low
);
  logic [STAGES-1:0] chain;

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge por_n) begin
          if (!por_n) chain[0] <= 1'b1;
          else        chain[0] <= pin_n;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge por_n) begin
          if (!por_n) chain[gi] <= 1'b1;
          else        chain[gi] <= chain[gi-1];
        end
      end
    end
  endgenerate

  assign pin_low = ~chain[STAGES-1];
endmodule

// File: rtl/spc_mode_fsm.sv
module spc_mode_fsm
  import spc_pkg::*;
#(
  parameter int unsigned ENTRY_CYCLES = 2,
  parameter int unsigned RST_CYCLES   = 16
) (
  input  logic      clk,
  input  logic      por_n,
  input  logic      stop_req,
  input  logic      deep_sel,
  input  logic      wake_req,
  input  logic      lvd_ok,
  output pm_state_e state,
  output logic      wake_fire
);
  localparam int unsigned CW = spc_cnt_width(ENTRY_CYCLES, RST_CYCLES);
  localparam logic [CW-1:0] ENTRY_LOAD = CW'(spc_load(ENTRY_CYCLES));
  localparam logic [CW-1:0] RST_LOAD   = CW'(spc_load(RST_CYCLES));

  logic [CW-1:0] cnt;
  logic          cnt_zero;
  logic          enter_go;

  assign cnt_zero  = (cnt == '0);
  assign enter_go  = (state == PM_RUN) && stop_req && deep_sel;
  assign wake_fire = (state == PM_STOPPED) && wake_req;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      state <= PM_WAKE_RST;
      cnt   <= RST_LOAD;
    end else begin
      unique case (state)
        PM_RUN: begin
          if (enter_go) begin
            state <= PM_ENTER;
            cnt   <= ENTRY_LOAD;
          end
        end
        PM_ENTER: begin
          if (cnt_zero) state <= PM_STOPPED;
          else          cnt   <= cnt - 1'b1;
        end
        PM_STOPPED: begin
          if (wake_fire) begin
            state <= PM_WAKE_RST;
            cnt   <= RST_LOAD;
          end
        end
        PM_WAKE_RST: begin
          if (!cnt_zero)   cnt   <= cnt - 1'b1;
          else if (lvd_ok) state <= PM_RUN;
        end
        default: state <= PM_WAKE_RST;
      endcase
    end
  end
endmodule

// File: rtl/spc_pdown_flag.sv
module spc_pdown_flag (
  input  logic clk,
  input  logic por_n,
  input  logic set_evt,
  input  logic ack_wr,
  input  logic ack_allowed,
  output logic flag
);
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                     flag <= 1'b0;
    else if (set_evt)               flag <= 1'b1;
    else if (ack_wr && ack_allowed) flag <= 1'b0;
  end
endmodule

// File: rtl/stop_pwr_ctl.sv
module stop_pwr_ctl
  import spc_pkg::*;
#(
  parameter int unsigned ENTRY_CYCLES = 2,
  parameter int unsigned RST_CYCLES   = 16,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic por_n,
  input  logic stop_req,
  input  logic deep_sel,
  input  logic wake_pin_n,
  input  logic rti_tick,
  input  logic rti_wake_en,
  input  logic dbg_en,
  input  logic lvd_ok,
  input  logic ack_wr,
  input  logic wake_pu_cfg,
  output logic periph_clk_en,
  output logic dbg_clk_en,
  output logic io_force_default,
  output logic core_pwr_on,
  output logic sys_rst,
  output logic pdown_flag,
  output logic wake_pu_en
);
  pm_state_e state;
  logic      pin_low;
  logic      rti_wake;
  logic      wake_req;
  logic      wake_fire;
  logic      in_run;

  spc_wake_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .por_n  (por_n),
    .pin_n  (wake_pin_n),
    .pin_low(pin_low)
  );

  assign rti_wake = rti_tick & rti_wake_en;
  assign wake_req = pin_low | rti_wake;

  spc_mode_fsm #(.ENTRY_CYCLES(ENTRY_CYCLES), .RST_CYCLES(RST_CYCLES)) u_fsm (
    .clk      (clk),
    .por_n    (por_n),
    .stop_req (stop_req),
    .deep_sel (deep_sel),
    .wake_req (wake_req),
    .lvd_ok   (lvd_ok),
    .state    (state),
    .wake_fire(wake_fire)
  );

  assign in_run = (state == PM_RUN);

  spc_pdown_flag u_flag (
    .clk        (clk),
    .por_n      (por_n),
    .set_evt    (wake_fire),
    .ack_wr     (ack_wr),
    .ack_allowed(in_run),
    .flag       (pdown_flag)
  );

  assign periph_clk_en    = in_run;
  assign dbg_clk_en       = in_run | dbg_en;
  assign io_force_default = ~in_run;
  assign core_pwr_on      = (state != PM_STOPPED);
  assign sys_rst          = (state == PM_WAKE_RST);
  assign wake_pu_en       = wake_pu_cfg;
endmodule

// File: rtl/stop_pwr_ctl_chk.sv
module stop_pwr_ctl_chk #(
  parameter int unsigned RST_CYCLES = 16
) (
  input logic clk,
  input logic por_n,
  input logic stop_req,
  input logic deep_sel,
  input logic rti_tick,
  input logic rti_wake_en,
  input logic lvd_ok,
  input logic ack_wr,
  input logic periph_clk_en,
  input logic io_force_default,
  input logic core_pwr_on,
  input logic sys_rst,
  input logic pdown_flag,
  input logic wake_fire
);
  logic [31:0] rst_len;
  logic        rst_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      rst_len <= '0;
      rst_q   <= 1'b1;
    end else begin
      rst_q   <= sys_rst;
      rst_len <= sys_rst ? ((rst_len == '1) ? rst_len : rst_len + 1'b1) : '0;
    end
  end

  AST_ENTRY_GATES: assert property (@(posedge clk) disable iff (!por_n)
    (stop_req && deep_sel && periph_clk_en) |=> (!periph_clk_en && io_force_default)); // R1
  AST_CORE_OFF_PADS: assert property (@(posedge clk) disable iff (!por_n)
    !core_pwr_on |-> io_force_default); // R1
  AST_SHALLOW_IGNORED: assert property (@(posedge clk) disable iff (!por_n)
    (stop_req && !deep_sel && periph_clk_en) |=> periph_clk_en); // R2
  AST_RTI_WAKE: assert property (@(posedge clk) disable iff (!por_n)
    (!core_pwr_on && rti_tick && rti_wake_en) |=> sys_rst); // R4
  AST_RST_MIN_LEN: assert property (@(posedge clk) disable iff (!por_n)
    (rst_q && !sys_rst) |-> (rst_len >= RST_CYCLES)); // R5
  AST_LVD_HOLD: assert property (@(posedge clk) disable iff (!por_n)
    (sys_rst && !lvd_ok) |=> sys_rst); // R6
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!por_n)
    wake_fire |=> (pdown_flag && sys_rst)); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!por_n)
    (pdown_flag && !(ack_wr && periph_clk_en)) |=> pdown_flag); // R7
  AST_PCLK_RUN_ONLY: assert property (@(posedge clk) disable iff (!por_n)
    (sys_rst || !core_pwr_on) |-> !periph_clk_en); // R9
endmodule

bind stop_pwr_ctl stop_pwr_ctl_chk #(.RST_CYCLES(RST_CYCLES)) u_chk (
  .clk             (clk),
  .por_n           (por_n),
  .stop_req        (stop_req),
  .deep_sel        (deep_sel),
  .rti_tick        (rti_tick),
  .rti_wake_en     (rti_wake_en),
  .lvd_ok          (lvd_ok),
  .ack_wr          (ack_wr),
  .periph_clk_en   (periph_clk_en),
  .io_force_default(io_force_default),
  .core_pwr_on     (core_pwr_on),
  .sys_rst         (sys_rst),
  .pdown_flag      (pdown_flag),
  .wake_fire       (wake_fire)
);

// File: tb/stop_pwr_ctl_test.sv
`timescale 1ns/1ps
module stop_pwr_ctl_test;
  localparam int ENTRY = 2;
  localparam int RSTN  = 16;

  logic clk = 1'b0;
  logic por_n, stop_req, deep_sel, wake_pin_n, rti_tick, rti_wake_en;
  logic dbg_en, lvd_ok, ack_wr, wake_pu_cfg;
  logic periph_clk_en, dbg_clk_en, io_force_default, core_pwr_on;
  logic sys_rst, pdown_flag, wake_pu_en;

  int n_chk  = 0;
  int n_fail = 0;
  bit cmp_on = 1'b0;

  always #2.5 clk = ~clk;

  stop_pwr_ctl uut (
    .clk(clk), .por_n(por_n), .stop_req(stop_req), .deep_sel(deep_sel),
    .wake_pin_n(wake_pin_n), .rti_tick(rti_tick), .rti_wake_en(rti_wake_en),
    .dbg_en(dbg_en), .lvd_ok(lvd_ok), .ack_wr(ack_wr), .wake_pu_cfg(wake_pu_cfg),
    .periph_clk_en(periph_clk_en), .dbg_clk_en(dbg_clk_en),
    .io_force_default(io_force_default), .core_pwr_on(core_pwr_on),
    .sys_rst(sys_rst), .pdown_flag(pdown_flag), .wake_pu_en(wake_pu_en)
  );

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Reference model: phase 0 run, 1 entering, 2 stopped, 3 restart
  int      m_ph;
  int      m_left;
  bit      m_flag;
  bit      m_wake;
  bit [1:0] m_hist;

  always @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      m_ph = 3; m_left = RSTN; m_flag = 0; m_hist = 2'b11;
    end else begin
      m_wake = (m_ph == 2) && (!m_hist[1] || (rti_tick && rti_wake_en));
      m_hist = {m_hist[0], wake_pin_n};
      case (m_ph)
        0: begin
          if (ack_wr) m_flag = 0;
          if (stop_req && deep_sel) begin m_ph = 1; m_left = ENTRY; end
        end
        1: begin m_left--; if (m_left == 0) m_ph = 2; end
        2: if (m_wake) begin m_ph = 3; m_left = RSTN; m_flag = 1; end
        default: begin
          if (m_left > 1) m_left--;
          else if (lvd_ok) m_ph = 0;
        end
      endcase
    end
  end

  always @(posedge clk) begin
    #1;
    if (cmp_on) begin
      chk("R9",  "periph_clk_en",    periph_clk_en,    m_ph == 0);
      chk("R9",  "dbg_clk_en",       dbg_clk_en,       (m_ph == 0) || dbg_en);
      chk("R1",  "io_force_default", io_force_default, m_ph != 0);
      chk("R1",  "core_pwr_on",      core_pwr_on,      m_ph != 2);
      chk("R5",  "sys_rst",          sys_rst,          m_ph == 3);
      chk("R7",  "pdown_flag",       pdown_flag,       m_flag);
      chk("R10", "wake_pu_en",       wake_pu_en,       wake_pu_cfg);
    end
  end

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int n;
    por_n = 0; stop_req = 0; deep_sel = 0; wake_pin_n = 1; rti_tick = 0;
    rti_wake_en = 0; dbg_en = 0; lvd_ok = 1; ack_wr = 0; wake_pu_cfg = 0;
    repeat (3) @(negedge clk);
    chk("R8", "sys_rst in por",   sys_rst, 1'b1);
    chk("R8", "flag in por",      pdown_flag, 1'b0);
    chk("R8", "periph in por",    periph_clk_en, 1'b0);
    chk("R8", "pads in por",      io_force_default, 1'b1);
    chk("R8", "core in por",      core_pwr_on, 1'b1);
    cmp_on = 1;
    por_n = 1;
    n = 0;
    while (sys_rst && n < 100) begin n++; @(negedge clk); end
    chk("R5", "por reset length is 16", n == RSTN, 1'b1);
    chk("R8", "flag clear after por", pdown_flag, 1'b0);

    // R2: shallow request ignored
    deep_sel = 0; stop_req = 1;
    @(negedge clk); stop_req = 0;
    for (int i = 0; i < 3; i++) begin
      chk("R2", "periph stays on", periph_clk_en, 1'b1);
      chk("R2", "pads not forced", io_force_default, 1'b0);
      @(negedge clk);
    end

    // R3: wake pin low in run is ignored
    wake_pin_n = 0;
    repeat (4) @(negedge clk);
    chk("R3", "no reset from pin in run", sys_rst, 1'b0);
    chk("R3", "still running", periph_clk_en, 1'b1);
    wake_pin_n = 1;
    repeat (3) @(negedge clk);

    // R1: deep entry sequence
    deep_sel = 1; stop_req = 1;
    @(negedge clk); stop_req = 0;
    chk("R1", "periph gated", periph_clk_en, 1'b0);
    chk("R1", "pads forced", io_force_default, 1'b1);
    chk("R1", "core on entering", core_pwr_on, 1'b1);
    @(negedge clk);
    chk("R1", "core on entering 2", core_pwr_on, 1'b1);
    @(negedge clk);
    chk("R1", "core off stopped", core_pwr_on, 1'b0);

    // R4: tick without enable ignored
    rti_tick = 1; rti_wake_en = 0;
    @(negedge clk); rti_tick = 0;
    chk("R4", "disabled tick ignored", core_pwr_on, 1'b0);
    chk("R4", "no reset on disabled tick", sys_rst, 1'b0);

    // R9 / R10 while stopped
    dbg_en = 1; wake_pu_cfg = 1;
    @(negedge clk);
    chk("R9",  "debug clock kept", dbg_clk_en, 1'b1);
    chk("R9",  "periph off in stop", periph_clk_en, 1'b0);
    chk("R10", "pull-up follows cfg", wake_pu_en, 1'b1);

    // R4 / R7: enabled tick wakes
    rti_tick = 1; rti_wake_en = 1;
    @(negedge clk); rti_tick = 0;
    chk("R4", "reset after tick", sys_rst, 1'b1);
    chk("R4", "core back on", core_pwr_on, 1'b1);
    chk("R7", "flag set on wake", pdown_flag, 1'b1);
    ack_wr = 1;
    @(negedge clk); ack_wr = 0;
    chk("R7", "ack in reset ignored", pdown_flag, 1'b1);
    n = 0;
    while (sys_rst && n < 40) begin n++; @(negedge clk); end
    chk("R7", "flag survives restart", pdown_flag, 1'b1);
    ack_wr = 1;
    @(negedge clk); ack_wr = 0;
    chk("R7", "ack clears flag", pdown_flag, 1'b0);

    // R3: pin wake timing
    dbg_en = 0; stop_req = 1;
    @(negedge clk); stop_req = 0;
    @(negedge clk);
    @(negedge clk);
    chk("R3", "stopped before pin", core_pwr_on, 1'b0);
    chk("R9", "debug clock off", dbg_clk_en, 1'b0);
    wake_pin_n = 0;
    @(negedge clk); wake_pin_n = 1;
    chk("R3", "stopped after edge k", core_pwr_on, 1'b0);
    @(negedge clk);
    chk("R3", "stopped after edge k+1", core_pwr_on, 1'b0);
    @(negedge clk);
    chk("R3", "reset after edge k+2", sys_rst, 1'b1);
    chk("R3", "core on after edge k+2", core_pwr_on, 1'b1);

    // R6: low supply holds reset
    lvd_ok = 0;
    repeat (25) @(negedge clk);
    chk("R6", "held in reset on low supply", sys_rst, 1'b1);
    lvd_ok = 1;
    @(negedge clk);
    chk("R6", "released after supply ok", sys_rst, 1'b0);
    chk("R7", "flag set by pin wake", pdown_flag, 1'b1);

    wake_pu_cfg = 0;
    @(negedge clk);
    chk("R10", "pull-up follows cfg low", wake_pu_en, 1'b0);
    repeat (2) @(negedge clk);
    summary();
    $finish;
  end
endmodule